// File: doc/BRIEF.md
# LIN Break Detector and Generator

This block watches a UART receive line for a LIN break (an abnormally long run of dominant low bit times), and it can drive a 13-bit-time break onto the transmit line on request. Timing comes from a bit-rate tick that an external baud generator supplies. The detector counts consecutive low samples, one per tick. A break counts as found only when that count has reached the selected threshold and the line then returns high, which is the break delimiter. At that point a sticky flag is raised, and an interrupt is asserted while the flag and its enable are both set.

Two configuration bits are held in the block: LIN operation on/off and the long/short threshold select. They are captured from a write strobe only while the block enable is low, so a configuration cannot change under live traffic. The detector and the transmit break generator are both inert unless the block is enabled and LIN operation is on. An optional receive inversion flips the line level before it reaches the detector. The receive line passes through a parameterised synchroniser.

Top module: `lin_brk_unit`

## Requirements
- R1: While the block enable is low or LIN operation is off, no break is flagged, a break request has no effect, and the transmit output stays high. If LIN operation is dropped during a break, the transmit output returns high.
- R2: With the threshold select at 0, a run of 10 low samples followed by a high sample sets the flag. A run of 9 low samples does not.
- R3: With the threshold select at 1, a run of 11 low samples followed by a high sample sets the flag. A run of 10 low samples does not.
- R4: The flag never sets while the line is still low. It sets on the first high sample after a run that reaches the threshold, including runs far longer than the threshold, where the counter saturates.
- R5: The interrupt output equals flag AND interrupt enable at all times.
- R6: The flag holds until a clear pulse arrives. A clear that coincides with a new detection leaves the flag set.
- R7: Configuration writes (LIN on, threshold select) made while the block enable is high are ignored.
- R8: With receive inversion set, a high level on the receive line is treated as low and a low level as high.
- R9: A break request drives the transmit output low from the first tick after the request for exactly 13 tick intervals. It then returns high, and a one-cycle done pulse occurs in the same cycle.
- R10: Any high sample clears the low-run count, so two short runs split by one high bit never add up to a break.
- R11: A break request made while a break is already being sent does not lengthen or restart it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| rx_line | input | 1 | Receive line, idle high |
| blk_enable | input | 1 | Block enable; configuration is locked while high |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_lin_on | input | 1 | Write data: LIN operation on |
| cfg_long_thr | input | 1 | Write data: 1 selects the 11-bit threshold, 0 the 10-bit threshold |
| rx_invert | input | 1 | Invert the receive level before detection |
| brk_irq_en | input | 1 | Interrupt enable |
| brk_send_req | input | 1 | Request to transmit a break |
| brk_flag_clr | input | 1 | Clears the break flag |
| tx_line | output | 1 | Transmit override, low while a break is sent |
| tx_brk_done | output | 1 | One-cycle pulse when a break finishes |
| brk_flag | output | 1 | Sticky break-detected flag |
| brk_irq | output | 1 | Interrupt |

## Verification
The detector is driven with low runs one bit short of the threshold and exactly at it, under both threshold settings. This separates an off-by-one threshold from a correct one, and a swapped select from a correct one. Runs held well past the threshold show whether the counter saturates or wraps. Two short runs split by a single high bit show whether a high sample clears the count. A run checked before its delimiter arrives shows whether detection waits for the line to return high. The generator is checked tick by tick over the full 13-bit window, and again with a second request arriving mid-break. Both functions are also exercised with LIN off, with the block disabled, with inverted reception, and with locked configuration writes.

// File: rtl/lin_brk_pkg.sv
package lin_brk_pkg;
   typedef enum logic [1:0] {
      GEN_IDLE  = 2'd0,
      GEN_ARMED = 2'd1,
      GEN_SEND  = 2'd2
   } gen_state_e;
endpackage

// File: rtl/lin_brk_cfg.sv
module lin_brk_cfg (
   input  logic clk,
   input  logic rst_n,
   input  logic blk_en_i,
   input  logic wr_i,
   input  logic lin_on_d_i,
   input  logic long_d_i,
   output logic lin_on_o,
   output logic long_o
);
   // configuration may only be written while the block is disabled
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lin_on_o <= 1'b0;
         long_o   <= 1'b0;
      end else if (wr_i && !blk_en_i) begin
         lin_on_o <= lin_on_d_i;
         long_o   <= long_d_i;
      end
   end

   assert_cfg_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      blk_en_i |=> ($stable(lin_on_o) && $stable(long_o)));
endmodule

// File: rtl/lin_brk_det.sv
module lin_brk_det #(
   parameter int SHORT_LEN   = 10,
   parameter int LONG_LEN    = 11,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active_i,
   input  logic tick_i,
   input  logic rx_i,
   input  logic inv_i,
   input  logic long_i,
   input  logic clr_i,
   output logic flag_o
);
   localparam int CNT_W = $clog2(LONG_LEN + 1);
   localparam logic [CNT_W-1:0] CNT_MAX   = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] THR_SHORT = CNT_W'(SHORT_LEN);
   localparam logic [CNT_W-1:0] THR_LONG  = CNT_W'(LONG_LEN);

   generate
      if (SHORT_LEN < 2 || LONG_LEN <= SHORT_LEN) begin : g_bad_len
         $error("lin_brk_det: need 2 <= SHORT_LEN < LONG_LEN");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("lin_brk_det: SYNC_STAGES must be non-negative");
      end
   endgenerate

   logic rx_s;
   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign rx_s = rx_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '1;
            else        sh_q <= (sh_q << 1) | SYNC_STAGES'(rx_i);
         end
         assign rx_s = sh_q[SYNC_STAGES-1];
      end
   endgenerate

   logic             level;
   logic [CNT_W-1:0] run_q;
   logic [CNT_W-1:0] thr;
   logic             set_ev;

   assign level  = rx_s ^ inv_i;
   assign thr    = long_i ? THR_LONG : THR_SHORT;
   assign set_ev = active_i && tick_i && level && (run_q >= thr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
      end else if (!active_i) begin
         run_q <= '0;
      end else if (tick_i) begin
         if (level)                run_q <= '0;
         else if (run_q != CNT_MAX) run_q <= run_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag_o <= 1'b0;
      else if (set_ev) flag_o <= 1'b1;
      else if (clr_i)  flag_o <= 1'b0;
   end

   assert_flag_on_delim_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_o) |-> $past(tick_i && level && active_i));
   assert_run_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (active_i && tick_i && level) |=> (run_q == '0));
   assert_idle_no_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!active_i && !flag_o) |=> !flag_o);
endmodule

// File: rtl/lin_brk_gen.sv
module lin_brk_gen
   import lin_brk_pkg::*;
#(
   parameter int BRK_LEN = 13
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active_i,
   input  logic tick_i,
   input  logic req_i,
   output logic tx_o,
   output logic done_o
);
   localparam int CW = (BRK_LEN > 1) ? $clog2(BRK_LEN) : 1;
   localparam logic [CW-1:0] LAST = CW'(BRK_LEN - 1);

   generate
      if (BRK_LEN < 1) begin : g_bad_len
         $error("lin_brk_gen: BRK_LEN must be at least 1");
      end
   endgenerate

   gen_state_e    st_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= GEN_IDLE;
         cnt_q  <= '0;
         done_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (!active_i) begin
            st_q <= GEN_IDLE;
         end else begin
            unique case (st_q)
               GEN_IDLE:  if (req_i) st_q <= GEN_ARMED;
               GEN_ARMED: if (tick_i) begin
                  st_q  <= GEN_SEND;
                  cnt_q <= '0;
               end
               GEN_SEND:  if (tick_i) begin
                  if (cnt_q == LAST) begin
                     st_q   <= GEN_IDLE;
                     done_o <= 1'b1;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               default:   st_q <= GEN_IDLE;
            endcase
         end
      end
   end

   assign tx_o = (st_q != GEN_SEND);

   assert_tx_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !active_i |=> tx_o);
   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   assert_done_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (tx_o && $past(!tx_o)));
endmodule

// File: rtl/lin_brk_unit.sv
module lin_brk_unit #(
   parameter int SHORT_LEN   = 10,
   parameter int LONG_LEN    = 11,
   parameter int BRK_LEN     = 13,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_tick,
   input  logic rx_line,
   input  logic blk_enable,
   input  logic cfg_wr,
   input  logic cfg_lin_on,
   input  logic cfg_long_thr,
   input  logic rx_invert,
   input  logic brk_irq_en,
   input  logic brk_send_req,
   input  logic brk_flag_clr,
   output logic tx_line,
   output logic tx_brk_done,
   output logic brk_flag,
   output logic brk_irq
);
   logic lin_on_q;
   logic long_q;
   logic active;

   lin_brk_cfg u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .blk_en_i   (blk_enable),
      .wr_i       (cfg_wr),
      .lin_on_d_i (cfg_lin_on),
      .long_d_i   (cfg_long_thr),
      .lin_on_o   (lin_on_q),
      .long_o     (long_q)
   );

   assign active = blk_enable && lin_on_q;

   lin_brk_det #(
      .SHORT_LEN   (SHORT_LEN),
      .LONG_LEN    (LONG_LEN),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_det (
      .clk      (clk),
      .rst_n    (rst_n),
      .active_i (active),
      .tick_i   (bit_tick),
      .rx_i     (rx_line),
      .inv_i    (rx_invert),
      .long_i   (long_q),
      .clr_i    (brk_flag_clr),
      .flag_o   (brk_flag)
   );

   lin_brk_gen #(
      .BRK_LEN (BRK_LEN)
   ) u_gen (
      .clk      (clk),
      .rst_n    (rst_n),
      .active_i (active),
      .tick_i   (bit_tick),
      .req_i    (brk_send_req),
      .tx_o     (tx_line),
      .done_o   (tx_brk_done)
   );

   assign brk_irq = brk_flag && brk_irq_en;

   assert_irq_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
      brk_irq |-> (brk_flag && brk_irq_en));
endmodule

// File: tb/tb_lin_brk_unit.sv
module tb_lin_brk_unit;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_tick = 0, rx_line = 1, blk_enable = 0, cfg_wr = 0;
   logic cfg_lin_on = 0, cfg_long_thr = 0, rx_invert = 0;
   logic brk_irq_en = 0, brk_send_req = 0, brk_flag_clr = 0;
   logic tx_line, tx_brk_done, brk_flag, brk_irq;

   int n_chk = 0;
   int n_fail = 0;

   // behavioural reference state
   bit m_lin, m_long, m_flag, m_done;
   int m_run, m_gst, m_gcnt;

   lin_brk_unit dut (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rx_line(rx_line),
      .blk_enable(blk_enable), .cfg_wr(cfg_wr), .cfg_lin_on(cfg_lin_on),
      .cfg_long_thr(cfg_long_thr), .rx_invert(rx_invert), .brk_irq_en(brk_irq_en),
      .brk_send_req(brk_send_req), .brk_flag_clr(brk_flag_clr),
      .tx_line(tx_line), .tx_brk_done(tx_brk_done), .brk_flag(brk_flag), .brk_irq(brk_irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_lin = 0; m_long = 0; m_flag = 0; m_done = 0;
         m_run = 0; m_gst = 0; m_gcnt = 0;
      end else begin
         bit act, lvl, set;
         int thr;
         act = blk_enable && m_lin;
         lvl = rx_line ^ rx_invert;
         thr = m_long ? 11 : 10;
         set = 0;
         if (!act) m_run = 0;
         else if (bit_tick) begin
            if (lvl) begin
               if (m_run >= thr) set = 1;
               m_run = 0;
            end else if (m_run < 15) m_run++;
         end
         if (set) m_flag = 1;
         else if (brk_flag_clr) m_flag = 0;
         m_done = 0;
         if (!act) m_gst = 0;
         else if (m_gst == 0) begin
            if (brk_send_req) m_gst = 1;
         end else if (m_gst == 1) begin
            if (bit_tick) begin m_gst = 2; m_gcnt = 0; end
         end else if (bit_tick) begin
            if (m_gcnt == 12) begin m_gst = 0; m_done = 1; end
            else m_gcnt++;
         end
         if (cfg_wr && !blk_enable) begin m_lin = cfg_lin_on; m_long = cfg_long_thr; end
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // cycle-by-cycle comparison against the reference
   always @(negedge clk) begin
      if (rst_n) begin
         chk(tx_line == (m_gst != 2), "R9 tx_line", tx_line, (m_gst != 2));
         chk(tx_brk_done == m_done, "R9 done", tx_brk_done, m_done);
         chk(brk_flag == m_flag, "R2 flag", brk_flag, m_flag);
         chk(brk_irq == (m_flag && brk_irq_en), "R5 irq", brk_irq, (m_flag && brk_irq_en));
      end
   end

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic bitt(input bit v, input bit clr_on_tick = 0);
      rx_line = v; bit_tick = 0;
      step(); step(); step();
      bit_tick = 1; brk_flag_clr = clr_on_tick;
      step();
      bit_tick = 0; brk_flag_clr = 0;
   endtask

   task automatic lows(input int n);
      for (int i = 0; i < n; i++) bitt(0);
   endtask

   task automatic clr_flag();
      brk_flag_clr = 1; step(); brk_flag_clr = 0;
   endtask

   task automatic write_cfg(input bit lin, input bit lng);
      cfg_lin_on = lin; cfg_long_thr = lng; cfg_wr = 1; step(); cfg_wr = 0;
   endtask

   initial begin
      #(CLK_PERIOD*200000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      step(); step();
      rst_n = 1;
      step();
      chk(tx_line == 1 && brk_flag == 0 && brk_irq == 0 && tx_brk_done == 0,
          "R1 reset state", {tx_line, brk_flag, brk_irq, tx_brk_done}, 4'b1000);

      // R1: LIN off, block enabled: nothing happens
      blk_enable = 1;
      lows(12); bitt(1);
      chk(brk_flag == 0, "R1 no flag when off", brk_flag, 0);
      brk_send_req = 1; step(); brk_send_req = 0;
      for (int i = 0; i < 15; i++) begin
         bitt(1);
         chk(tx_line == 1, "R1 tx idle when off", tx_line, 1);
      end

      // configure short threshold, LIN on
      blk_enable = 0; write_cfg(1, 0); blk_enable = 1;

      // R2: 9 lows is not enough
      lows(9); bitt(1);
      chk(brk_flag == 0, "R2 9 lows no flag", brk_flag, 0);
      // R4: 10 lows, no flag before delimiter
      lows(10);
      chk(brk_flag == 0, "R4 no flag while low", brk_flag, 0);
      bitt(1);
      chk(brk_flag == 1, "R2 10 lows flag", brk_flag, 1);

      // R5 / R6
      brk_irq_en = 0; step();
      chk(brk_irq == 0, "R5 irq masked", brk_irq, 0);
      brk_irq_en = 1; step();
      chk(brk_irq == 1, "R5 irq asserted", brk_irq, 1);
      bitt(1); bitt(1);
      chk(brk_flag == 1, "R6 flag sticky", brk_flag, 1);
      clr_flag();
      chk(brk_flag == 0 && brk_irq == 0, "R6 clear", brk_flag, 0);

      // R7: write while enabled is ignored (threshold stays short)
      write_cfg(1, 1);
      lows(10); bitt(1);
      chk(brk_flag == 1, "R7 locked cfg", brk_flag, 1);
      clr_flag();

      // R3: long threshold
      blk_enable = 0; write_cfg(1, 1); blk_enable = 1;
      lows(10); bitt(1);
      chk(brk_flag == 0, "R3 10 lows no flag", brk_flag, 0);
      lows(11); bitt(1);
      chk(brk_flag == 1, "R3 11 lows flag", brk_flag, 1);
      clr_flag();

      // R10: split runs do not add up
      lows(6); bitt(1); lows(6); bitt(1);
      chk(brk_flag == 0, "R10 split runs", brk_flag, 0);

      // R4: saturation on a long run
      lows(20); bitt(1);
      chk(brk_flag == 1, "R4 long run flag", brk_flag, 1);
      clr_flag();

      // R6: clear together with detection leaves flag set
      lows(11); bitt(1, 1);
      chk(brk_flag == 1, "R6 set beats clear", brk_flag, 1);
      clr_flag();

      // R8: inverted reception
      rx_invert = 1; rx_line = 0; step(); step(); step();
      for (int i = 0; i < 11; i++) bitt(1);
      chk(brk_flag == 0, "R8 no flag before delim", brk_flag, 0);
      bitt(0);
      chk(brk_flag == 1, "R8 inverted break", brk_flag, 1);
      rx_invert = 0; rx_line = 1; step(); step(); step();
      clr_flag();

      // R9 / R11: transmit break
      brk_send_req = 1; step(); brk_send_req = 0;
      chk(tx_line == 1, "R9 tx high before tick", tx_line, 1);
      bitt(1);
      chk(tx_line == 0, "R9 tx low first tick", tx_line, 0);
      for (int i = 0; i < 12; i++) begin
         if (i == 5) begin brk_send_req = 1; step(); brk_send_req = 0; end
         bitt(1);
         chk(tx_line == 0, "R11 tx low mid break", tx_line, 0);
      end
      bitt(1);
      chk(tx_line == 1 && tx_brk_done == 1, "R9 release and done", {tx_line, tx_brk_done}, 2'b11);
      step();
      chk(tx_brk_done == 0, "R9 done one cycle", tx_brk_done, 0);
      bitt(1);
      chk(tx_line == 1, "R11 no restart", tx_line, 1);

      // R1: disabling mid break releases tx
      brk_send_req = 1; step(); brk_send_req = 0;
      bitt(1); bitt(1);
      chk(tx_line == 0, "R1 break running", tx_line, 0);
      blk_enable = 0; step(); step();
      chk(tx_line == 1, "R1 tx released on disable", tx_line, 1);

      step(); step();
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule